// File: doc/BRIEF.md
# Reset-Sampled Boot Configuration Register

The block takes a snapshot of a group of board-level strap inputs when reset goes away. The straps are a 3-bit pinout mode, a chip-select-2 width select, a 3-bit PLL multiplier, a fast-boot flag, an endianness select and a PCI enable. The snapshot is kept in a read-only status word. The same snapshot also gives the power-on values of the software-writable control fields: the effective pinout mode and the per-space bus-width bits. After that point the straps may wander and nothing inside changes. Software may later rewrite the writable fields through a small register port. The snapshot itself stays fixed until the next reset.

The outputs feed neighbouring logic: the pin router (effective pinout mode, PCI pin function, pull-resistor enables), the external memory controller (one width bit per chip-select space), the core (endianness) and the clock generator (PLL multiplier). The PLL multiplier is passed on only when fast boot was strapped. Otherwise the block drives a bypass code of 0.

Top module: `bootcfg_latch`

## Requirements
- R1: The status word at address 0 holds the strap values sampled at the last rising clock edge with `rst_n` low. Its layout is bits [2:0] pinout mode, [3] CS2 width, [6:4] PLL multiplier, [7] fast boot, [8] endianness and [9] PCI enable; the remaining bits read 0. Strap changes after reset release do not alter it.
- R2: Writes to address 0 are accepted and change neither the status word nor any output.
- R3: The bus-width word at address 2 holds one bit per chip-select space, and bit 0 is chip-select space 2 (0 = 8-bit, 1 = 16-bit). At reset, bit 0 takes the CS2 width strap and every other bit is 0. A write replaces all bits, and the new value appears on `cs_wide` one clock after the write edge.
- R4: Bits [2:0] of the pin-mux word at address 1 are writable, and their reset value is the pinout-mode strap. `pinmode_eff` follows this field, and a write takes effect one clock after the write edge.
- R5: Writing the bus-width word leaves `pinmode_eff` unchanged. Writing the pin-mux word leaves `cs_wide` unchanged.
- R6: `pll_mul` equals the sampled PLL multiplier when the sampled fast-boot flag is 1, and equals 0 when it is 0.
- R7: `little_endian` equals the sampled endianness strap (1 = little endian, 0 = big endian) and cannot be changed by software.
- R8: The sampled PCI enable reads back in status bit 9 and in pin-mux bit 8. Both copies are read-only. `pci_mode` equals the sampled value and `pull_en` is its inverse.
- R9: While `rst_n` is low, register writes are ignored and the writable fields follow the straps.
- R10: Reads of addresses 3 and above return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; its release freezes the strap snapshot |
| cfg_pinmode | input | 3 | Pinout-mode strap |
| cfg_wide_cs2 | input | 1 | CS2 width strap (1 = 16-bit) |
| cfg_pllmul | input | 3 | PLL multiplier strap |
| cfg_fastboot | input | 1 | Fast-boot strap |
| cfg_little | input | 1 | Endianness strap (1 = little) |
| cfg_pci_en | input | 1 | PCI enable strap |
| reg_addr | input | ADDR_W | Register word address |
| reg_we | input | 1 | Write enable |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from the address |
| pinmode_eff | output | 3 | Effective pinout mode |
| cs_wide | output | NUM_CS | Per-space 16-bit width, bit 0 = CS2 |
| little_endian | output | 1 | Endianness in use |
| pll_mul | output | 3 | PLL multiplier, 0 when fast boot is off |
| pci_mode | output | 1 | Shared pins in PCI function |
| pull_en | output | 1 | Internal pull resistors enabled on the shared pins |

## Verification
Reads are combinational, so the bench samples `reg_rdata` 1 ns after it changes the address, inside the same low clock phase. Writes go through a single register stage. The bench drives a write at a falling edge and checks `pinmode_eff` and `cs_wide` at the next falling edge, half a period after the capturing rising edge. The snapshot is taken at the last rising edge with reset low. The bench releases reset at a falling edge, changes the straps at the next one, and only then checks the status word, the read-only copies and the fixed outputs.

// File: rtl/bootcfg_latch.sv
module bootcfg_latch #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int NUM_CS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_pinmode,
  input  logic              cfg_wide_cs2,
  input  logic [2:0]        cfg_pllmul,
  input  logic              cfg_fastboot,
  input  logic              cfg_little,
  input  logic              cfg_pci_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [2:0]        pinmode_eff,
  output logic [NUM_CS-1:0] cs_wide,
  output logic              little_endian,
  output logic [2:0]        pll_mul,
  output logic              pci_mode,
  output logic              pull_en
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MUX  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CSW  = ADDR_W'(2);

  logic [2:0]        mode_q, pll_q, mux_q;
  logic              wide_q, fb_q, little_q, pci_q;
  logic [NUM_CS-1:0] csw_q;
  logic              unused_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= cfg_pinmode;
      wide_q   <= cfg_wide_cs2;
      pll_q    <= cfg_pllmul;
      fb_q     <= cfg_fastboot;
      little_q <= cfg_little;
      pci_q    <= cfg_pci_en;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mux_q <= cfg_pinmode;
      csw_q <= {{(NUM_CS-1){1'b0}}, cfg_wide_cs2};
    end else if (reg_we) begin
      if (reg_addr == A_MUX) mux_q <= reg_wdata[2:0];
      if (reg_addr == A_CSW) csw_q <= reg_wdata[NUM_CS-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_STAT: reg_rdata[9:0] = {pci_q, little_q, fb_q, pll_q, wide_q, mode_q};
      A_MUX: begin
        reg_rdata[2:0] = mux_q;
        reg_rdata[8]   = pci_q;
      end
      A_CSW: reg_rdata[NUM_CS-1:0] = csw_q;
      default: reg_rdata = '0;
    endcase
  end

  assign unused_wdata  = ^reg_wdata;
  assign pinmode_eff   = mux_q;
  assign cs_wide       = csw_q;
  assign little_endian = little_q;
  assign pll_mul       = fb_q ? pll_q : 3'd0;
  assign pci_mode      = pci_q;
  assign pull_en       = ~pci_q;
endmodule

// File: rtl/bootcfg_latch_chk.sv
module bootcfg_latch_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        cfg_pinmode,
  input logic              cfg_wide_cs2,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_we,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [2:0]        pinmode_eff,
  input logic [NUM_CS-1:0] cs_wide,
  input logic              little_endian,
  input logic [2:0]        pll_mul,
  input logic              pci_mode,
  input logic              pull_en,
  input logic              fb_q
);
  AST_STATUS_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(reg_addr) == '0 && reg_addr == '0) |-> $stable(reg_rdata)); // R2
  AST_CSW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(reg_we) && $past(reg_addr) == ADDR_W'(2)) |-> cs_wide == $past(reg_wdata[NUM_CS-1:0])); // R3
  AST_MUX_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(reg_we) && $past(reg_addr) == ADDR_W'(1)) |-> pinmode_eff == $past(reg_wdata[2:0])); // R4
  AST_CSW_NO_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(reg_we) && $past(reg_addr) == ADDR_W'(2)) |-> $stable(pinmode_eff)); // R5
  AST_PLL_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    !fb_q |-> pll_mul == 3'd0); // R6
  AST_ENDIAN_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(little_endian)); // R7
  AST_PCI_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($stable(pci_mode) && $stable(pull_en) && pull_en != pci_mode)); // R8
  AST_RESET_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (pinmode_eff == $past(cfg_pinmode) &&
                       cs_wide == {{(NUM_CS-1){1'b0}}, $past(cfg_wide_cs2)})); // R9
endmodule

bind bootcfg_latch bootcfg_latch_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CS(NUM_CS)) u_chk (.*);

// File: tb/test_bootcfg_latch.sv
`timescale 1ns/1ps
module test_bootcfg_latch;
  localparam int AW = 4, DW = 32, NC = 4;

  logic clk = 0, rst_n = 0;
  logic [2:0] cfg_pinmode = 0, cfg_pllmul = 0;
  logic cfg_wide_cs2 = 0, cfg_fastboot = 0, cfg_little = 0, cfg_pci_en = 0;
  logic [AW-1:0] reg_addr = 0;
  logic reg_we = 0;
  logic [DW-1:0] reg_wdata = 0;
  logic [DW-1:0] reg_rdata;
  logic [2:0] pinmode_eff, pll_mul;
  logic [NC-1:0] cs_wide;
  logic little_endian, pci_mode, pull_en;

  int checks = 0, errors = 0;
  logic done = 0;

  logic [2:0] m_mode, m_pll, e_mode;
  logic m_wide, m_fb, m_lit, m_pci;
  logic [NC-1:0] e_cs;

  always #5 clk = ~clk;

  bootcfg_latch #(.ADDR_W(AW), .DATA_W(DW), .NUM_CS(NC)) i_bootcfg_latch (.*);

  function automatic logic [DW-1:0] exp_status();
    logic [DW-1:0] v = '0;
    v[9:0] = {m_pci, m_lit, m_fb, m_pll, m_wide, m_mode};
    return v;
  endfunction

  function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
    logic [DW-1:0] v = '0;
    case (a)
      0: v = exp_status();
      1: begin v[2:0] = e_mode; v[8] = m_pci; end
      2: v[NC-1:0] = e_cs;
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic scramble_pins();
    cfg_pinmode  = 3'($urandom);
    cfg_wide_cs2 = 1'($urandom);
    cfg_pllmul   = 3'($urandom);
    cfg_fastboot = 1'($urandom);
    cfg_little   = 1'($urandom);
    cfg_pci_en   = 1'($urandom);
  endtask

  task automatic check_outs();
    check("R4 pinmode_eff", DW'(pinmode_eff), DW'(e_mode));
    check("R3 cs_wide", DW'(cs_wide), DW'(e_cs));
    check("R7 little_endian", DW'(little_endian), DW'(m_lit));
    check("R6 pll_mul", DW'(pll_mul), DW'(m_fb ? m_pll : 3'd0));
    check("R8 pci_mode", DW'(pci_mode), DW'(m_pci));
    check("R8 pull_en", DW'(pull_en), DW'(!m_pci));
  endtask

  task automatic do_read(input logic [AW-1:0] a, input string req);
    @(negedge clk);
    reg_we = 0;
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp_read(a));
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk);
    reg_we = 0;
    if (a == 1) e_mode = d[2:0];
    if (a == 2) e_cs = d[NC-1:0];
    check_outs();
  endtask

  task automatic do_reset(input logic [2:0] pm, input logic w, input logic [2:0] pl,
                          input logic fb, input logic li, input logic pc);
    @(negedge clk);
    rst_n = 0;
    cfg_pinmode = pm; cfg_wide_cs2 = w; cfg_pllmul = pl;
    cfg_fastboot = fb; cfg_little = li; cfg_pci_en = pc;
    reg_addr = 1; reg_wdata = {DW{1'b1}} ^ DW'(pm); reg_we = 1;
    repeat (3) @(negedge clk);
    reg_addr = 2; reg_wdata = {DW{1'b1}};
    @(negedge clk);
    reg_we = 0;
    rst_n = 1;
    m_mode = pm; m_wide = w; m_pll = pl; m_fb = fb; m_lit = li; m_pci = pc;
    e_mode = pm; e_cs = {{(NC-1){1'b0}}, w};
    @(negedge clk);
    scramble_pins();
    @(negedge clk);
    check("R9 mode default under reset writes", DW'(pinmode_eff), DW'(pm));
    check("R9 width default under reset writes", DW'(cs_wide), DW'(e_cs));
    check_outs();
    do_read(0, "R1 status snapshot");
    do_read(1, "R8 mux word with pci copy");
    do_read(2, "R3 width reset value");
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);

    do_reset(3'd5, 1'b1, 3'd6, 1'b0, 1'b1, 1'b1);
    check("R6 bypass when fast boot off", DW'(pll_mul), 0);
    do_reset(3'd2, 1'b0, 3'd7, 1'b1, 1'b0, 1'b0);
    check("R6 multiplier when fast boot on", DW'(pll_mul), 7);
    check("R8 pulls on when pci off", DW'(pull_en), 1);

    do_write(0, {DW{1'b1}});
    do_read(0, "R2 status after write");
    do_write(1, 32'h0000_0107);
    do_read(1, "R8 pci copy after write");
    do_write(2, 32'h0000_000A);
    check("R5 width write keeps mode", DW'(pinmode_eff), 7);
    do_write(1, 32'h0000_0003);
    check("R5 mode write keeps width", DW'(cs_wide), 32'hA);
    do_read(3, "R10 unmapped 3");
    do_read(15, "R10 unmapped 15");

    for (int r = 0; r < 8; r++) begin
      do_reset(3'($urandom), 1'($urandom), 3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      for (int k = 0; k < 40; k++) begin
        logic [AW-1:0] a;
        a = ($urandom % 4 == 0) ? AW'($urandom) : AW'($urandom % 3);
        scramble_pins();
        if ($urandom % 2 == 0) do_write(a, $urandom);
        else do_read(a, a == 0 ? "R1 status stays fixed" : (a > 2 ? "R10 unmapped" : "R4 R3 readback"));
      end
      do_read(0, "R2 status after random writes");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule